// File: doc/BRIEF.md
# Clocked SRAM Command Port with Power-Down

This block is the synchronous SRAM-side front end of a cached memory. It holds a 1K x 16 array arranged as 128 blocks of eight 16-bit words. On each rising clock edge it takes one command from a 3-bit code: no-operation, deselect, read or write. Data is handled in two byte lanes. A separate active-low strobe puts the port into power-down. Read data goes through an output register. Output tristate behaviour is modelled with a data-valid flag and one drive-enable flag per byte lane, and both are gated by an active-low output enable.

Power-down starts one edge after the strobe is seen low. While the port is powered down, commands, addresses and write data have no effect, and the registered output state is frozen. The outputs still follow output enable. The strobe is still sampled so that the port can wake. A deselect command blocks all array access, but it loads the per-lane drive state, so output drive can be switched without toggling output enable.

Top module: `sram_cmd_port`

## Requirements
- R1: The address selects one of 1024 words. Bits 9:3 pick one of 128 blocks and bits 2:0 pick one of 8 words in that block. A full-word write followed by a read of the same address returns the written word.
- R2: On a write (cmd 3'b011), `lane_en[1]` enables writing bits 15:8 and `lane_en[0]` enables writing bits 7:0. A lane whose enable is low keeps its old byte.
- R3: A read (cmd 3'b010) sampled at edge N puts the addressed word in the output register after edge N. It stays there until the next read.
- R4: After a read, `drv[i]` equals `lane_en[i]` as sampled with the read, ANDed with `~oe_n`. `rvalid` is high when `oe_n` is low. `rdata` shows each driven lane's byte and zero in each undriven lane.
- R5: After a no-operation (cmd 3'b000), `drv` is 0 and `rvalid` is 0.
- R6: A deselect (cmd 3'b001) leaves the array unchanged. It loads the drive state from `lane_en` and clears the valid state. The output register keeps the last read data.
- R7: After a write, `drv` is 0 and `rvalid` is 0.
- R8: If `pd_n` is sampled low while the port is awake, the command at that edge still executes. From the next edge on, commands are ignored and the drive, valid and read-data state is frozen.
- R9: While the port is powered down, `oe_n` still gates `drv`, `rvalid` and `rdata`.
- R10: If `pd_n` is sampled high while the port is powered down, the port wakes. The command at that edge is ignored, and commands are accepted again from the next edge.
- R11: A synchronous active-high `rst` clears power-down, clears drive, valid and read data, and leaves the array contents undefined.
- R12: Command codes 3'b100 to 3'b111 act as a no-operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low power-down strobe |
| cmd | input | 3 | Command code |
| addr | input | 10 | Word address: block in 9:3, word in 2:0 |
| lane_en | input | 2 | Per-lane control: bit 1 upper byte, bit 0 lower byte |
| oe_n | input | 1 | Active-low output enable |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero in undriven lanes |
| rvalid | output | 1 | Data-valid flag |
| drv | output | 2 | Per-lane drive enable |

## Verification
The bench builds the block with its default parameters: 10 address bits, 3 word-select bits and two byte lanes. With these values the whole 1024-word array can be filled and read back one address at a time, and the full 128-block by 8-word decode is exercised. Both byte lanes are covered in every mask combination. A behavioural model with its own memory and power-down state is compared against the outputs on every cycle. The stimulus includes writes and the wake edge during power-down, a reset taken while powered down, and a long mixed run of all eight command codes.

// File: rtl/sram_cmd_port.sv
module sram_cmd_port #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 3,
  parameter int LANES  = 2,
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_en,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [LANES-1:0]  drv
);
  localparam int BLOCKS = 1 << (ADDR_W - WORD_W);
  localparam int WORDS  = 1 << WORD_W;
  localparam logic [2:0] CMD_NOP = 3'b000;
  localparam logic [2:0] CMD_DES = 3'b001;
  localparam logic [2:0] CMD_RD  = 3'b010;
  localparam logic [2:0] CMD_WR  = 3'b011;

  logic                     asleep;
  logic [LANES-1:0]         ln_q;
  logic                     vq;
  logic [ADDR_W-WORD_W-1:0] blk;
  logic [WORD_W-1:0]        wrd;
  logic                     acc;

  assign blk    = addr[ADDR_W-1:WORD_W];
  assign wrd    = addr[WORD_W-1:0];
  assign acc    = ~rst & ~asleep;
  assign drv    = ln_q & {LANES{~oe_n}};
  assign rvalid = vq & ~oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep <= 1'b0;
      ln_q   <= '0;
      vq     <= 1'b0;
    end else if (asleep) begin
      if (pd_n) asleep <= 1'b0;
    end else begin
      if (!pd_n) asleep <= 1'b1;
      case (cmd)
        CMD_RD:  begin ln_q <= lane_en; vq <= 1'b1; end
        CMD_DES: begin ln_q <= lane_en; vq <= 1'b0; end
        default: begin ln_q <= '0;      vq <= 1'b0; end
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] arr [BLOCKS][WORDS];
    logic [7:0] rd_b;

    always_ff @(posedge clk) begin
      if (acc && cmd == CMD_WR && lane_en[g]) arr[blk][wrd] <= wdata[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst) rd_b <= '0;
      else if (acc && cmd == CMD_RD) rd_b <= arr[blk][wrd];
    end

    assign rdata[8*g +: 8] = drv[g] ? rd_b : 8'h00;
  end

  // R8
  pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!asleep && !pd_n) |=> asleep);

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |=> ($stable(ln_q) && $stable(vq)));

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (asleep && pd_n) |=> !asleep);

  // R5
  nop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!asleep && cmd == CMD_NOP) |=> (drv == '0 && !rvalid));

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!asleep && cmd == CMD_WR) |=> (drv == '0 && !rvalid));

  // R3
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!asleep && cmd == CMD_RD) |=> vq);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (drv == '0 && !rvalid && rdata == '0));
endmodule

// File: tb/test_sram_cmd_port.sv
module test_sram_cmd_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n = 1'b1;
  logic [2:0] cmd = 3'b000;
  logic [9:0] addr = '0;
  logic [1:0] lane_en = 2'b00;
  logic oe_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rvalid;
  logic [1:0] drv;

  sram_cmd_port i_sram_cmd_port (
    .clk(clk), .rst(rst), .pd_n(pd_n), .cmd(cmd), .addr(addr),
    .lane_en(lane_en), .oe_n(oe_n), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .drv(drv)
  );

  always #10 clk = ~clk;

  logic [15:0] m_mem [1024];
  logic        m_sleep = 1'b0;
  logic [1:0]  m_lane  = 2'b00;
  logic        m_valid = 1'b0;
  logic [15:0] m_data  = '0;
  int vectors = 0;
  int fails = 0;
  int ncyc = 0;
  string tag = "R11";

  always @(posedge clk) begin
    if (rst) begin
      m_sleep = 1'b0; m_lane = 2'b00; m_valid = 1'b0; m_data = '0;
    end else if (m_sleep) begin
      if (pd_n) m_sleep = 1'b0;
    end else begin
      if (!pd_n) m_sleep = 1'b1;
      if (cmd == 3'd2) begin
        m_data = m_mem[addr]; m_lane = lane_en; m_valid = 1'b1;
      end else if (cmd == 3'd1) begin
        m_lane = lane_en; m_valid = 1'b0;
      end else begin
        if (cmd == 3'd3) begin
          if (lane_en[1]) m_mem[addr][15:8] = wdata[15:8];
          if (lane_en[0]) m_mem[addr][7:0]  = wdata[7:0];
        end
        m_lane = 2'b00; m_valid = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", ncyc, 100000);
      finish_run();
    end
  end

  task automatic check();
    logic [1:0] ed;
    logic ev;
    logic [15:0] edat;
    ed = m_lane & {2{~oe_n}};
    ev = m_valid & ~oe_n;
    edat = {ed[1] ? m_data[15:8] : 8'h00, ed[0] ? m_data[7:0] : 8'h00};
    vectors++;
    if (drv !== ed || rvalid !== ev || rdata !== edat) begin
      fails++;
      $display("FAIL %s: drv=%b rvalid=%b rdata=%h expected drv=%b rvalid=%b rdata=%h",
               tag, drv, rvalid, rdata, ed, ev, edat);
    end
  endtask

  task automatic cyc(input logic [2:0] c, input logic [9:0] a, input logic [1:0] l,
                     input logic o, input logic p, input logic [15:0] d);
    @(negedge clk);
    check();
    cmd = c; addr = a; lane_en = l; oe_n = o; pd_n = p; wdata = d;
  endtask

  initial begin
    // R11: reset state
    tag = "R11";
    cyc(3'd0, 10'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd0, 10'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    rst = 1'b0;

    // R1: fill every word, then read each back (R3, R4)
    tag = "R1";
    for (int a = 0; a < 1024; a++)
      cyc(3'd3, 10'(a), 2'b11, 1'b0, 1'b1, 16'(a * 16'h9e37) ^ 16'h5a5a);
    tag = "R1/R3";
    for (int a = 0; a < 1024; a++)
      cyc(3'd2, 10'(a), 2'b11, 1'b0, 1'b1, 16'h0);

    // R2: byte-masked writes
    tag = "R2";
    cyc(3'd3, 10'd5, 2'b10, 1'b0, 1'b1, 16'hAAAA);
    cyc(3'd3, 10'd6, 2'b01, 1'b0, 1'b1, 16'hBBBB);
    cyc(3'd3, 10'd7, 2'b00, 1'b0, 1'b1, 16'hCCCC);
    cyc(3'd2, 10'd5, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd6, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd7, 2'b11, 1'b0, 1'b1, 16'h0);

    // R4: lane masks and output enable
    tag = "R4";
    cyc(3'd2, 10'd900, 2'b01, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd901, 2'b10, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd902, 2'b00, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd903, 2'b11, 1'b1, 1'b1, 16'h0);
    cyc(3'd0, 10'd0,   2'b11, 1'b0, 1'b1, 16'h0);

    // R5: no-operation clears drive
    tag = "R5";
    cyc(3'd0, 10'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd33, 2'b11, 1'b0, 1'b1, 16'h0);

    // R7: write clears drive
    tag = "R7";
    cyc(3'd3, 10'd34, 2'b11, 1'b0, 1'b1, 16'h1234);
    cyc(3'd2, 10'd34, 2'b11, 1'b0, 1'b1, 16'h0);

    // R6: deselect sets drive from lanes, keeps data, touches no word
    tag = "R6";
    cyc(3'd1, 10'd34, 2'b10, 1'b0, 1'b1, 16'hFFFF);
    cyc(3'd1, 10'd34, 2'b01, 1'b1, 1'b1, 16'hFFFF);
    cyc(3'd1, 10'd34, 2'b11, 1'b0, 1'b1, 16'hFFFF);
    cyc(3'd2, 10'd34, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd0, 10'd0,  2'b00, 1'b0, 1'b1, 16'h0);

    // R12: upper codes behave as no-operation
    tag = "R12";
    for (int c = 4; c < 8; c++) begin
      cyc(3'd2, 10'd40, 2'b11, 1'b0, 1'b1, 16'h0);
      cyc(3'(c), 10'd40, 2'b11, 1'b0, 1'b1, 16'hDEAD);
    end
    cyc(3'd2, 10'd40, 2'b11, 1'b0, 1'b1, 16'h0);

    // R8: command with strobe low executes, later writes ignored
    tag = "R8";
    cyc(3'd2, 10'd50, 2'b11, 1'b0, 1'b0, 16'h0);
    cyc(3'd3, 10'd50, 2'b11, 1'b0, 1'b0, 16'hBEEF);
    cyc(3'd3, 10'd51, 2'b11, 1'b0, 1'b0, 16'hBEEF);
    cyc(3'd0, 10'd0,  2'b00, 1'b0, 1'b0, 16'h0);
    // R9: output enable still gates while asleep
    tag = "R9";
    cyc(3'd0, 10'd0, 2'b00, 1'b1, 1'b0, 16'h0);
    cyc(3'd0, 10'd0, 2'b00, 1'b0, 1'b0, 16'h0);
    cyc(3'd0, 10'd0, 2'b00, 1'b1, 1'b0, 16'h0);
    // R10: wake edge ignores its command
    tag = "R10";
    cyc(3'd3, 10'd52, 2'b11, 1'b0, 1'b1, 16'hF00D);
    cyc(3'd2, 10'd50, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd51, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd2, 10'd52, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd0, 10'd0,  2'b00, 1'b0, 1'b1, 16'h0);

    // R11: reset while asleep
    tag = "R11";
    cyc(3'd2, 10'd60, 2'b11, 1'b0, 1'b0, 16'h0);
    cyc(3'd0, 10'd0,  2'b00, 1'b0, 1'b0, 16'h0);
    rst = 1'b1;
    cyc(3'd0, 10'd0,  2'b00, 1'b0, 1'b0, 16'h0);
    rst = 1'b0;
    cyc(3'd2, 10'd61, 2'b11, 1'b0, 1'b1, 16'h0);
    cyc(3'd0, 10'd0,  2'b00, 1'b0, 1'b1, 16'h0);

    // Mixed run across all requirements (R1-style traffic plus R8/R10 toggling)
    tag = "mixed R2/R4/R8";
    for (int i = 0; i < 3000; i++)
      cyc(3'($urandom_range(0, 7)), 10'($urandom_range(0, 1023)),
          2'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0),
          ($urandom_range(0, 7) != 0), 16'($urandom));

    cyc(3'd0, 10'd0, 2'b00, 1'b0, 1'b1, 16'h0);
    finish_run();
  end
endmodule